// File: doc/BRIEF.md
# Transition-Coded Isolated Logic Link

This block models a bundle of one-way logic lines that cross an isolation barrier between a system side and a field side. Each line has a transmitter on the side that drives it and a receiver on the other side. The transmitter sends a short message whenever its input changes: the message tells the receiver to go high or to go low. The receiver holds the last level it was told in a latch. A background timer on each line resends the current level when the line has been quiet for a full refresh window. This lets a receiver that missed a message, or that has just come out of reset, settle without waiting for an edge.

Each side has its own enable. While an enable is low, that side's outputs are released to high impedance and the inputs it drives are frozen at their last level. Raising the enable again shows the latched levels at once. It also pushes the present input levels of that side across the barrier. After a reset on either side, both sides stay idle for a power-up hold-off. A fixed-latency pipeline stands in for the barrier delay.

Tri-state pins are modelled as a level output plus an output-enable per pin. The parameter `SYS_TX_LINES` selects how many of the low-numbered lines the system side drives. The remaining lines are driven from the field side.

Top module: `iso_edge_link`

## Requirements
- R1: Lines 0 to SYS_TX_LINES-1 are driven from the system side and appear on the field pins. The other lines are driven from the field side and appear on the system pins. A pin is never output-enabled on the side that drives its line.
- R2: A change on an enabled input reaches the opposite output exactly BARRIER_CYC+2 clock edges later, and not one edge earlier.
- R3: A receiver output level changes only in the cycle after a message for that line leaves the barrier pipeline.
- R4: After either reset is released, every output-enable stays low for PWRUP_CYC clock edges. Input changes made during that hold-off are not carried.
- R5: With no input edges after the hold-off, each line's output becomes valid with the correct level PWRUP_CYC+REFRESH_CYC+BARRIER_CYC+1 edges after reset release. In general this happens within two refresh windows of the hold-off ending.
- R6: A low enable on a side clears every output-enable on that side at once. While it is low, input changes on that side are ignored, and the far side keeps the last level it received.
- R7: When a side's enable rises, its outputs show the latched levels immediately. The present level of each input on that side reaches the far side BARRIER_CYC+2 edges later.
- R8: A pulse of five clock cycles is reproduced at the far output with both edges shifted by the same latency.
- R9: Asserting the reset of either side drops every output-enable on both sides, and the full hold-off and recovery sequence runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common clock for both sides |
| sys_rst_ni | input | 1 | System-side power-on reset, active low |
| fld_rst_ni | input | 1 | Field-side power-on reset, active low |
| sys_en_i | input | 1 | System-side enable; low releases system outputs and freezes system inputs |
| fld_en_i | input | 1 | Field-side enable; low releases field outputs and freezes field inputs |
| sys_pin_i | input | NUM_LINES | System pin levels (used on lines the system side drives) |
| sys_pin_o | output | NUM_LINES | System pin output levels |
| sys_pin_oe_o | output | NUM_LINES | System pin output-enables |
| fld_pin_i | input | NUM_LINES | Field pin levels (used on lines the field side drives) |
| fld_pin_o | output | NUM_LINES | Field pin output levels |
| fld_pin_oe_o | output | NUM_LINES | Field pin output-enables |

## Verification
The bench times the recovery after reset to the exact edge. A design that sent a message as soon as the hold-off ended, or that started the refresh timer one cycle late, would show outputs too early or too late. It toggles inputs during the hold-off and while a side is disabled. A design that forwarded those changes would show the new level on the far side instead of the held one. It checks the edge one cycle before the expected arrival, and it sends a pulse of five cycles. An extra or missing pipeline stage, or a receiver that copied levels instead of waiting for messages, would shift or lose one of the pulse edges. It also pulls one reset alone to show that both sides go dark.

// File: rtl/iso_link_pkg.sv
`timescale 1ns/1ps
package iso_link_pkg;
  typedef struct packed {
    logic vld;
    logic lvl;
  } msg_t;
endpackage

// File: rtl/iso_pwrup_hold.sv
`timescale 1ns/1ps
module iso_pwrup_hold #(
  parameter int unsigned HOLD_CYC = 6000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic run_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (cnt_q != CW'(HOLD_CYC)) cnt_q <= cnt_q + 1'b1;
  end

  assign run_o = (cnt_q == CW'(HOLD_CYC));
endmodule

// File: rtl/iso_tx_lane.sv
`timescale 1ns/1ps
module iso_tx_lane
  import iso_link_pkg::*;
#(
  parameter int unsigned REFRESH_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic en_i,
  input  logic pin_i,
  output msg_t msg_o
);
  localparam int unsigned TW = $clog2(REFRESH_CYC);

  logic          last_q, en_q;
  logic [TW-1:0] tmr_q;
  msg_t          msg_q;
  logic          lvl_now, chg, en_rise, tmr_hit, send;

  always_comb begin
    lvl_now = en_i ? pin_i : last_q;   // frozen while disabled
    chg     = en_i & (pin_i ^ last_q);
    en_rise = en_i & ~en_q;
    tmr_hit = (tmr_q == TW'(REFRESH_CYC - 1));
    send    = run_i & (chg | tmr_hit | en_rise);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      en_q   <= 1'b1;
      tmr_q  <= '0;
      msg_q  <= '0;
    end else begin
      en_q      <= en_i;
      msg_q.vld <= send;
      msg_q.lvl <= lvl_now;
      if (!run_i) begin
        last_q <= pin_i;               // track so run start is not an edge
        tmr_q  <= '0;
      end else begin
        last_q <= lvl_now;
        tmr_q  <= send ? '0 : tmr_q + 1'b1;
      end
    end
  end

  assign msg_o = msg_q;
endmodule

// File: rtl/iso_barrier_pipe.sv
`timescale 1ns/1ps
module iso_barrier_pipe
  import iso_link_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 5,
  parameter int unsigned BARRIER_CYC = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  msg_t [NUM_LINES-1:0] msg_i,
  output msg_t [NUM_LINES-1:0] msg_o
);
  if (BARRIER_CYC == 0) begin : g_wire
    assign msg_o = msg_i;
  end else begin : g_pipe
    msg_t [NUM_LINES-1:0] stg_q [BARRIER_CYC];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < int'(BARRIER_CYC); k++) stg_q[k] <= '0;
      end else if (!run_i) begin
        for (int k = 0; k < int'(BARRIER_CYC); k++) stg_q[k] <= '0;
      end else begin
        stg_q[0] <= msg_i;
        for (int k = 1; k < int'(BARRIER_CYC); k++) stg_q[k] <= stg_q[k-1];
      end
    end

    assign msg_o = stg_q[BARRIER_CYC-1];
  end
endmodule

// File: rtl/iso_rx_lane.sv
`timescale 1ns/1ps
module iso_rx_lane
  import iso_link_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  msg_t msg_i,
  output logic lvl_o,
  output logic valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o   <= 1'b0;
      valid_o <= 1'b0;
    end else if (!run_i) begin
      lvl_o   <= 1'b0;
      valid_o <= 1'b0;
    end else if (msg_i.vld) begin
      lvl_o   <= msg_i.lvl;
      valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/iso_edge_link.sv
`timescale 1ns/1ps
module iso_edge_link
  import iso_link_pkg::*;
#(
  parameter int unsigned NUM_LINES    = 5,
  parameter int unsigned SYS_TX_LINES = 3,
  parameter int unsigned REFRESH_CYC  = 1000,
  parameter int unsigned PWRUP_CYC    = 6000,
  parameter int unsigned BARRIER_CYC  = 3
) (
  input  logic                 clk_i,
  input  logic                 sys_rst_ni,
  input  logic                 fld_rst_ni,
  input  logic                 sys_en_i,
  input  logic                 fld_en_i,
  input  logic [NUM_LINES-1:0] sys_pin_i,
  output logic [NUM_LINES-1:0] sys_pin_o,
  output logic [NUM_LINES-1:0] sys_pin_oe_o,
  input  logic [NUM_LINES-1:0] fld_pin_i,
  output logic [NUM_LINES-1:0] fld_pin_o,
  output logic [NUM_LINES-1:0] fld_pin_oe_o
);
  function automatic logic [NUM_LINES-1:0] low_mask(int unsigned n);
    logic [NUM_LINES-1:0] m;
    m = '0;
    for (int i = 0; i < int'(NUM_LINES); i++) m[i] = (i < int'(n));
    return m;
  endfunction

  localparam logic [NUM_LINES-1:0] SYS_MASK = low_mask(SYS_TX_LINES);

  logic                 both_rst_n, run;
  logic [NUM_LINES-1:0] tx_pin, tx_en, rx_arr, rx_lvl, rx_valid;
  msg_t [NUM_LINES-1:0] tx_msg, rx_msg;

  // reset on either side restarts the whole link
  assign both_rst_n = sys_rst_ni & fld_rst_ni;

  iso_pwrup_hold #(.HOLD_CYC(PWRUP_CYC)) u_hold (
    .clk_i (clk_i),
    .rst_ni(both_rst_n),
    .run_o (run)
  );

  assign tx_pin = (SYS_MASK & sys_pin_i) | (~SYS_MASK & fld_pin_i);
  assign tx_en  = (SYS_MASK & {NUM_LINES{sys_en_i}}) | (~SYS_MASK & {NUM_LINES{fld_en_i}});

  for (genvar i = 0; i < int'(NUM_LINES); i++) begin : g_tx
    iso_tx_lane #(.REFRESH_CYC(REFRESH_CYC)) u_tx (
      .clk_i (clk_i),
      .rst_ni(both_rst_n),
      .run_i (run),
      .en_i  (tx_en[i]),
      .pin_i (tx_pin[i]),
      .msg_o (tx_msg[i])
    );
  end

  iso_barrier_pipe #(.NUM_LINES(NUM_LINES), .BARRIER_CYC(BARRIER_CYC)) u_bar (
    .clk_i (clk_i),
    .rst_ni(both_rst_n),
    .run_i (run),
    .msg_i (tx_msg),
    .msg_o (rx_msg)
  );

  for (genvar i = 0; i < int'(NUM_LINES); i++) begin : g_rx
    assign rx_arr[i] = rx_msg[i].vld;
    iso_rx_lane u_rx (
      .clk_i  (clk_i),
      .rst_ni (both_rst_n),
      .run_i  (run),
      .msg_i  (rx_msg[i]),
      .lvl_o  (rx_lvl[i]),
      .valid_o(rx_valid[i])
    );
  end

  assign fld_pin_o    = SYS_MASK & rx_lvl;
  assign fld_pin_oe_o = SYS_MASK & rx_valid & {NUM_LINES{fld_en_i & run}};
  assign sys_pin_o    = ~SYS_MASK & rx_lvl;
  assign sys_pin_oe_o = ~SYS_MASK & rx_valid & {NUM_LINES{sys_en_i & run}};
endmodule

// File: rtl/iso_edge_link_chk.sv
`timescale 1ns/1ps
module iso_edge_link_chk #(
  parameter int unsigned NUM_LINES   = 5,
  parameter int unsigned REFRESH_CYC = 1000,
  parameter int unsigned PWRUP_CYC   = 6000,
  parameter int unsigned BARRIER_CYC = 3
) (
  input logic                 clk_i,
  input logic                 sys_rst_ni,
  input logic                 fld_rst_ni,
  input logic                 sys_en_i,
  input logic                 fld_en_i,
  input logic [NUM_LINES-1:0] sys_pin_oe_o,
  input logic [NUM_LINES-1:0] fld_pin_oe_o,
  input logic                 run_i,
  input logic [NUM_LINES-1:0] rx_arr_i,
  input logic [NUM_LINES-1:0] rx_lvl_i,
  input logic [NUM_LINES-1:0] rx_valid_i
);
  localparam int unsigned LIMIT = 2 * REFRESH_CYC + BARRIER_CYC + 2;
  localparam int unsigned HW    = $clog2(PWRUP_CYC + 1);
  localparam int unsigned LW    = $clog2(LIMIT + 1);

  logic          rst_n;
  logic [HW-1:0] hold_cnt;
  logic [LW-1:0] run_cnt;

  assign rst_n = sys_rst_ni & fld_rst_ni;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      run_cnt  <= '0;
    end else begin
      if (hold_cnt != HW'(PWRUP_CYC))        hold_cnt <= hold_cnt + 1'b1;
      if (run_i && run_cnt != LW'(LIMIT))    run_cnt  <= run_cnt + 1'b1;
    end
  end

  a_r4_holdoff_hiz: assert property (@(posedge clk_i) disable iff (!rst_n)
    (hold_cnt < HW'(PWRUP_CYC)) |-> (sys_pin_oe_o == '0 && fld_pin_oe_o == '0));

  a_r6_sys_disable_hiz: assert property (@(posedge clk_i) disable iff (!rst_n)
    !sys_en_i |-> (sys_pin_oe_o == '0));

  a_r6_fld_disable_hiz: assert property (@(posedge clk_i) disable iff (!rst_n)
    !fld_en_i |-> (fld_pin_oe_o == '0));

  a_r3_latch_on_msg: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_i && rx_arr_i == '0) |=> ($stable(rx_lvl_i) && $stable(rx_valid_i)));

  a_r5_valid_by_two_windows: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_cnt == LW'(LIMIT)) |-> (&rx_valid_i));
endmodule

bind iso_edge_link iso_edge_link_chk #(
  .NUM_LINES  (NUM_LINES),
  .REFRESH_CYC(REFRESH_CYC),
  .PWRUP_CYC  (PWRUP_CYC),
  .BARRIER_CYC(BARRIER_CYC)
) u_chk (
  .clk_i       (clk_i),
  .sys_rst_ni  (sys_rst_ni),
  .fld_rst_ni  (fld_rst_ni),
  .sys_en_i    (sys_en_i),
  .fld_en_i    (fld_en_i),
  .sys_pin_oe_o(sys_pin_oe_o),
  .fld_pin_oe_o(fld_pin_oe_o),
  .run_i       (run),
  .rx_arr_i    (rx_arr),
  .rx_lvl_i    (rx_lvl),
  .rx_valid_i  (rx_valid)
);

// File: tb/iso_edge_link_tb.sv
`timescale 1ns/1ps
module iso_edge_link_tb;
  localparam int N   = 5;
  localparam int S   = 3;
  localparam int R   = 40;
  localparam int P   = 20;
  localparam int L   = 3;
  localparam int LAT = L + 2;   // equals the 5-cycle pulse width used in R8

  logic         clk = 1'b0;
  logic         sys_rst_n, fld_rst_n, sys_en, fld_en;
  logic [N-1:0] sys_pin_i, sys_pin_o, sys_pin_oe, fld_pin_i, fld_pin_o, fld_pin_oe;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  iso_edge_link #(
    .NUM_LINES(N), .SYS_TX_LINES(S), .REFRESH_CYC(R), .PWRUP_CYC(P), .BARRIER_CYC(L)
  ) u_dut (
    .clk_i(clk), .sys_rst_ni(sys_rst_n), .fld_rst_ni(fld_rst_n),
    .sys_en_i(sys_en), .fld_en_i(fld_en),
    .sys_pin_i(sys_pin_i), .sys_pin_o(sys_pin_o), .sys_pin_oe_o(sys_pin_oe),
    .fld_pin_i(fld_pin_i), .fld_pin_o(fld_pin_o), .fld_pin_oe_o(fld_pin_oe)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_powerup();
    bit quiet = 1'b1;
    sys_rst_n = 0; fld_rst_n = 0; sys_en = 1; fld_en = 1;
    sys_pin_i = 5'b00101; fld_pin_i = 5'b10000;
    tick(2);
    chk("R4 reset hiz", int'({sys_pin_oe, fld_pin_oe}), 0);
    sys_rst_n = 1; fld_rst_n = 1;
    for (int c = 1; c <= P; c++) begin
      tick(1);
      if (sys_pin_oe != '0 || fld_pin_oe != '0) quiet = 1'b0;
      if (c == 3) begin sys_pin_i ^= 5'b00111; fld_pin_i ^= 5'b11000; end
      if (c == 8) begin sys_pin_i ^= 5'b00111; fld_pin_i ^= 5'b11000; end
    end
    chk("R4 holdoff quiet", int'(quiet), 1);
    tick(R + L);
    chk("R5 not before refresh", int'(fld_pin_oe), 0);
    tick(1);
    chk("R5 fld oe", int'(fld_pin_oe), 'b00111);
    chk("R5 fld level", int'(fld_pin_o & 5'b00111), 'b00101);
    chk("R5 sys oe", int'(sys_pin_oe), 'b11000);
    chk("R5 sys level", int'(sys_pin_o & 5'b11000), 'b10000);
  endtask

  task automatic t_edge();
    sys_pin_i[1] = 1'b1;
    tick(LAT - 1);
    chk("R2 sys->fld early", int'(fld_pin_o[1]), 0);
    tick(1);
    chk("R2 sys->fld arrive", int'(fld_pin_o[1]), 1);
    chk("R1 sys-driven lines not out on sys", int'(sys_pin_oe & 5'b00111), 0);
    chk("R1 fld-driven lines not out on fld", int'(fld_pin_oe & 5'b11000), 0);
    fld_pin_i[3] = 1'b1;
    tick(LAT - 1);
    chk("R2 fld->sys early", int'(sys_pin_o[3]), 0);
    tick(1);
    chk("R2 fld->sys arrive", int'(sys_pin_o[3]), 1);
  endtask

  task automatic t_hold();
    tick(3 * R);
    chk("R3 fld held", int'(fld_pin_o & 5'b00111), 'b00111);
    chk("R3 sys held", int'(sys_pin_o & 5'b11000), 'b11000);
  endtask

  task automatic t_pulse();
    sys_pin_i[0] = 1'b0;
    tick(LAT - 1);
    chk("R8 before fall", int'(fld_pin_o[0]), 1);
    tick(1);
    chk("R8 fall", int'(fld_pin_o[0]), 0);
    sys_pin_i[0] = 1'b1;
    tick(LAT - 1);
    chk("R8 low width", int'(fld_pin_o[0]), 0);
    tick(1);
    chk("R8 rise", int'(fld_pin_o[0]), 1);
  endtask

  task automatic t_disable();
    sys_en = 1'b0;
    #1;
    chk("R6 sys hiz", int'(sys_pin_oe), 0);
    sys_pin_i[2] = 1'b0;
    fld_pin_i[4] = 1'b0;
    tick(2 * R);
    chk("R6 frozen input ignored", int'(fld_pin_o[2]), 1);
    chk("R6 far side still driven", int'(fld_pin_oe), 'b00111);
    sys_en = 1'b1;
    #1;
    chk("R7 sys oe back", int'(sys_pin_oe), 'b11000);
    chk("R7 sys shows latched level", int'(sys_pin_o[4]), 0);
    tick(LAT - 1);
    chk("R7 update not early", int'(fld_pin_o[2]), 1);
    tick(1);
    chk("R7 present level sent", int'(fld_pin_o[2]), 0);
    fld_en = 1'b0;
    #1;
    chk("R6 fld hiz", int'(fld_pin_oe), 0);
    fld_en = 1'b1;
    tick(1);
  endtask

  task automatic t_rereset();
    fld_rst_n = 1'b0;
    #1;
    chk("R9 both sides dark", int'({sys_pin_oe, fld_pin_oe}), 0);
    tick(2);
    fld_rst_n = 1'b1;
    tick(P + R + L);
    chk("R9 still in recovery", int'(fld_pin_oe), 0);
    tick(1);
    chk("R9 fld recovered", int'(fld_pin_oe), 'b00111);
    chk("R9 fld level", int'(fld_pin_o & 5'b00111), 'b00011);
    chk("R9 sys recovered", int'(sys_pin_oe), 'b11000);
    chk("R9 sys level", int'(sys_pin_o & 5'b11000), 'b01000);
  endtask

  initial begin
    t_powerup();
    t_edge();
    t_hold();
    t_pulse();
    t_disable();
    t_rereset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule